// File: doc/BRIEF.md
# Approximate DST-VII / DCT-VIII Adjustment Wrapper

This block sits around a DCT-II vector core that can run forward or inverse. With cheap stages placed before and after that core, it gives an approximate DST-VII or DCT-VIII, forward or inverse, for 16-point and 32-point vectors. The stages use three operations. An index reversal maps position i to position n-1-i. An alternating sign change negates every odd position. A sparse band adjustment matrix has at most five taps per row, and its coefficients are parameters.

A job enters as one parallel vector together with its controls:

- the direction (forward or inverse),
- the transform kind,
- the size.

In the same cycle as the core's start pulse, the wrapper sends the prepared vector to the core. It waits for the core's valid. One cycle after that valid, it returns the finished vector with a one-cycle output valid.

A three-state machine sequences each job:

- `ST_IDLE` accepts a job and moves to `ST_CORE`.
- `ST_CORE` waits for the core's valid and then moves to `ST_DONE`.
- `ST_DONE` spends one cycle there and returns to `ST_IDLE`.

Top module: `wp_adjust_wrap`

## Requirements
- R1: While reset is held, and in the first cycle after it, `core_start` and `out_valid` are low.
- R2: A job is accepted when `in_valid` is high in `ST_IDLE`. In the next cycle `core_start` is high for exactly one cycle, and at the same time `core_vec_o` and `core_size32` are valid. `out_valid` rises one cycle after `core_valid` has been seen in `ST_CORE`, and stays high for exactly one cycle.
- R3: `in_valid` is ignored in `ST_CORE` and in `ST_DONE`: no new core start, and no change to the job in flight.
- R4: Kind codes are 0 for DCT-II, 1 for DST-VII and 2 for DCT-VIII. `core_inv` equals `in_inv` for DCT-II. It is the complement of `in_inv` for DST-VII and DCT-VIII. It stays stable while the core is working.
- R5: DCT-II in either direction: the core receives the input vector unchanged, and the output is the core result unchanged.
- R6: Forward DST-VII: the core receives rev(A·x), and the output is the sign-alternated core result.
- R7: Inverse DST-VII: the core receives the sign-alternated input, and the output is Aᵀ·rev(y).
- R8: Forward DCT-VIII: the core receives rev(A·rev(x)), and the output is the core result unchanged.
- R9: Inverse DCT-VIII: the core receives the input unchanged, and the output is rev(Aᵀ·rev(y)).
- R10: Row r of A weights element r+t-2 with its tap t (t = 0..4); taps that fall outside the vector count as zero. The coefficients are signed 8-bit values. Each adjusted element is the full-precision sum, plus 2^(SHIFT-1), arithmetically shifted right by SHIFT (default 6), keeping the low DW bits. Coefficients that are powers of two are applied as shifts.
- R11: With size 16 (`in_size32`=0), reversal spans 16 elements, input elements 16..31 are ignored, and output elements 16..31 are zero.
- R12: Kind code 3 acts as DCT-II. A size whose coefficient table is all zero also turns DST-VII and DCT-VIII requests into DCT-II.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Job request |
| in_inv | input | 1 | 0 forward, 1 inverse |
| in_kind | input | 2 | Transform kind code |
| in_size32 | input | 1 | 1 for 32-point, 0 for 16-point |
| in_vec | input | NMAX*DW | Input vector, element i at bits [i*DW +: DW] |
| core_start | output | 1 | One-cycle start to the core |
| core_inv | output | 1 | Core direction, 1 = inverse DCT-II |
| core_size32 | output | 1 | Core size |
| core_vec_o | output | NMAX*DW | Prepared vector to the core |
| core_valid | input | 1 | Core result valid |
| core_vec_i | input | NMAX*DW | Core result vector |
| out_valid | output | 1 | One-cycle result valid |
| out_vec | output | NMAX*DW | Result vector |

## Verification
The bound checker watches every cycle for the following:

- that both valid strobes are single-cycle pulses;
- that accepting a job and seeing the core's valid each lead to their strobe one cycle later;
- that a request arriving during `ST_CORE` starts nothing;
- that the core direction and size stay steady while the core works;
- that a 16-point result has a zero upper half.

The numeric content cannot be read from local relations: the reversal, the sign pattern, the band products with their rounding, and the fallback rules. Only the bench's reference model can check it, by comparing the core-side and output vectors across all kinds, directions and sizes. A second instance with an all-zero 16-point table covers the fallback.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam int VEC_MAX   = 32;
    localparam int BAND_TAPS = 5;
    localparam int COEF_W    = 8;
    localparam int TAB_W     = VEC_MAX * BAND_TAPS * COEF_W;

    typedef enum logic [1:0] {
        XF_DCT2 = 2'd0,
        XF_DST7 = 2'd1,
        XF_DCT8 = 2'd2
    } xf_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CORE = 2'd1,
        ST_DONE = 2'd2
    } wp_state_e;

    // Default band table: row r, tap t weights element r+t-2; entries off the
    // vector edge stay zero, so edge rows carry fewer taps.
    function automatic logic [TAB_W-1:0] band_table(input int n);
        logic [TAB_W-1:0]          tab;
        logic signed [COEF_W-1:0]  v;
        int                        c;
        tab = '0;
        for (int r = 0; r < n; r++) begin
            for (int t = 0; t < BAND_TAPS; t++) begin
                c = r + t - 2;
                v = '0;
                if (c >= 0 && c < n) begin
                    case (t)
                        0:       v = (r % 4 == 0) ? COEF_W'(2) : COEF_W'(0);
                        1:       v = (r % 2 == 1) ? COEF_W'(8) : COEF_W'(-5);
                        2:       v = (r == n - 1) ? COEF_W'(64) : COEF_W'(60 - (r % 3) * 2);
                        3:       v = (r % 3 == 0) ? COEF_W'(-4) : COEF_W'(3);
                        default: v = (r % 4 == 0) ? COEF_W'(-1) : COEF_W'(0);
                    endcase
                end
                tab[(r * BAND_TAPS + t) * COEF_W +: COEF_W] = v;
            end
        end
        return tab;
    endfunction

endpackage

// File: rtl/wp_perm.sv
module wp_perm #(
    parameter int DW   = 16,
    parameter int NMAX = 32
) (
    input  logic               wide,
    input  logic               rev,
    input  logic               neg,
    input  logic [NMAX*DW-1:0] vin,
    output logic [NMAX*DW-1:0] vout
);
    localparam int HALF_N = NMAX / 2;

    for (genvar i = 0; i < NMAX; i++) begin : g_el
        logic [DW-1:0] e;
        always_comb begin
            int            n;
            int            src;
            logic [DW-1:0] x;
            n   = wide ? NMAX : HALF_N;
            src = rev ? (n - 1 - i) : i;
            x   = '0;
            if (i < n) x = vin[src*DW +: DW];
            e = (neg && (i % 2 == 1)) ? DW'(-x) : x;
        end
        assign vout[i*DW +: DW] = e;
    end

endmodule

// File: rtl/wp_band.sv
module wp_band #(
    parameter int DW     = 16,
    parameter int NMAX   = 32,
    parameter int SHIFT  = 6,
    parameter bit TRANSP = 1'b0,
    parameter logic [NMAX*wp_pkg::BAND_TAPS*wp_pkg::COEF_W-1:0] C_LO = '0,
    parameter logic [NMAX*wp_pkg::BAND_TAPS*wp_pkg::COEF_W-1:0] C_HI = '0
) (
    input  logic               wide,
    input  logic [NMAX*DW-1:0] vin,
    output logic [NMAX*DW-1:0] vout
);
    localparam int TAPS = wp_pkg::BAND_TAPS;
    localparam int CW   = wp_pkg::COEF_W;
    localparam int PW   = DW + CW + 1;
    localparam int SW   = PW + $clog2(TAPS) + 1;
    localparam logic signed [SW-1:0] HALF = SW'(1) <<< (SHIFT - 1);

    function automatic logic signed [CW-1:0] tap(input logic [NMAX*TAPS*CW-1:0] tab,
                                                 input int r, input int t);
        return $signed(tab[(r * TAPS + t) * CW +: CW]);
    endfunction

    // Constant coefficient times element; powers of two become shifts.
    function automatic logic signed [PW-1:0] cmul(input logic signed [CW-1:0] c,
                                                  input logic signed [DW-1:0] v);
        logic signed [CW:0]   cx;
        logic [CW:0]          mag;
        logic signed [PW-1:0] ve;
        logic signed [PW-1:0] p;
        int                   k;
        cx  = c;
        ve  = v;
        mag = cx[CW] ? $unsigned(-cx) : $unsigned(cx);
        k   = 0;
        for (int b = 0; b <= CW; b++) if (mag[b]) k = b;
        if (mag == '0) begin
            p = '0;
        end else if ((mag & (mag - 1'b1)) == '0) begin
            p = ve <<< k;
            if (cx[CW]) p = -p;
        end else begin
            p = ve * PW'(cx);
        end
        return p;
    endfunction

    for (genvar i = 0; i < NMAX; i++) begin : g_el
        logic [DW-1:0] e;
        always_comb begin
            logic signed [SW-1:0] s_lo;
            logic signed [SW-1:0] s_hi;
            logic signed [SW-1:0] s;
            s_lo = '0;
            s_hi = '0;
            for (int t = 0; t < TAPS; t++) begin
                int j;
                int r;
                j = TRANSP ? (i + 2 - t) : (i + t - 2);
                r = TRANSP ? j : i;
                if (j >= 0 && j < NMAX) begin
                    s_lo = s_lo + SW'(cmul(tap(C_LO, r, t), vin[j*DW +: DW]));
                    s_hi = s_hi + SW'(cmul(tap(C_HI, r, t), vin[j*DW +: DW]));
                end
            end
            s = wide ? s_hi : s_lo;
            e = DW'((s + HALF) >>> SHIFT);
        end
        assign vout[i*DW +: DW] = e;
    end

endmodule

// File: rtl/wp_adjust_wrap.sv
module wp_adjust_wrap
    import wp_pkg::*;
#(
    parameter int DW    = 16,
    parameter int NMAX  = wp_pkg::VEC_MAX,
    parameter int SHIFT = 6,
    parameter logic [wp_pkg::TAB_W-1:0] C16 = wp_pkg::band_table(16),
    parameter logic [wp_pkg::TAB_W-1:0] C32 = wp_pkg::band_table(32)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_inv,
    input  logic [1:0]         in_kind,
    input  logic               in_size32,
    input  logic [NMAX*DW-1:0] in_vec,
    output logic               core_start,
    output logic               core_inv,
    output logic               core_size32,
    output logic [NMAX*DW-1:0] core_vec_o,
    input  logic               core_valid,
    input  logic [NMAX*DW-1:0] core_vec_i,
    output logic               out_valid,
    output logic [NMAX*DW-1:0] out_vec
);
    localparam int VW   = NMAX * DW;
    localparam bit Z_LO = (C16 == '0);
    localparam bit Z_HI = (C32 == '0);

    function automatic xf_kind_e resolve(input logic [1:0] k, input logic wide);
        if ((k == XF_DST7 || k == XF_DCT8) && !(wide ? Z_HI : Z_LO))
            return xf_kind_e'(k);
        return XF_DCT2;
    endfunction

    wp_state_e state, nxt;
    xf_kind_e  job_kind;
    logic      job_inv;
    logic      job_wide;

    // ---------------- pre-stage (live request controls) ----------------
    xf_kind_e        pk;
    logic            p_adj, pa_rev, pa_neg;
    logic [VW-1:0]   pa_v, pb_v, pc_v, pre_vec;

    always_comb begin
        pk     = resolve(in_kind, in_size32);
        p_adj  = !in_inv && (pk != XF_DCT2);
        pa_rev = !in_inv && (pk == XF_DCT8);
        pa_neg =  in_inv && (pk == XF_DST7);
    end

    wp_perm #(.DW(DW), .NMAX(NMAX)) u_pre_a (
        .wide(in_size32), .rev(pa_rev), .neg(pa_neg), .vin(in_vec), .vout(pa_v));
    wp_band #(.DW(DW), .NMAX(NMAX), .SHIFT(SHIFT), .TRANSP(1'b0), .C_LO(C16), .C_HI(C32))
        u_pre_band (.wide(in_size32), .vin(pa_v), .vout(pb_v));
    wp_perm #(.DW(DW), .NMAX(NMAX)) u_pre_b (
        .wide(in_size32), .rev(1'b1), .neg(1'b0), .vin(pb_v), .vout(pc_v));

    assign pre_vec = p_adj ? pc_v : pa_v;

    // ---------------- post-stage (latched job controls) ----------------
    logic            q_adj, qc_rev, qc_neg;
    logic [VW-1:0]   qa_v, qb_v, qc_v, post_vec;

    always_comb begin
        q_adj  =  job_inv && (job_kind != XF_DCT2);
        qc_rev = q_adj;
        qc_neg = !job_inv && (job_kind == XF_DST7);
    end

    wp_perm #(.DW(DW), .NMAX(NMAX)) u_post_a (
        .wide(job_wide), .rev(qc_rev), .neg(qc_neg), .vin(core_vec_i), .vout(qa_v));
    wp_band #(.DW(DW), .NMAX(NMAX), .SHIFT(SHIFT), .TRANSP(1'b1), .C_LO(C16), .C_HI(C32))
        u_post_band (.wide(job_wide), .vin(qa_v), .vout(qb_v));
    wp_perm #(.DW(DW), .NMAX(NMAX)) u_post_b (
        .wide(job_wide), .rev(1'b1), .neg(1'b0), .vin(qb_v), .vout(qc_v));

    assign post_vec = !q_adj ? qa_v : ((job_kind == XF_DCT8) ? qc_v : qb_v);

    assign core_inv    = job_inv ^ (job_kind != XF_DCT2);
    assign core_size32 = job_wide;

    // ---------------- state machine ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (in_valid)   nxt = ST_CORE;
            ST_CORE: if (core_valid) nxt = ST_DONE;
            ST_DONE:                 nxt = ST_IDLE;
            default:                 nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_start <= 1'b0;
            out_valid  <= 1'b0;
            core_vec_o <= '0;
            out_vec    <= '0;
            job_kind   <= XF_DCT2;
            job_inv    <= 1'b0;
            job_wide   <= 1'b0;
        end else begin
            core_start <= 1'b0;
            out_valid  <= 1'b0;
            unique case (state)
                ST_IDLE: if (in_valid) begin
                    core_start <= 1'b1;
                    core_vec_o <= pre_vec;
                    job_kind   <= pk;
                    job_inv    <= in_inv;
                    job_wide   <= in_size32;
                end
                ST_CORE: if (core_valid) begin
                    out_valid <= 1'b1;
                    out_vec   <= post_vec;
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/wp_adjust_chk.sv
module wp_adjust_chk #(
    parameter int DW   = 16,
    parameter int NMAX = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               core_start,
    input logic               core_valid,
    input logic               core_inv,
    input logic               core_size32,
    input logic               out_valid,
    input logic [NMAX*DW-1:0] out_vec,
    input logic [1:0]         state
);
    localparam int VW   = NMAX * DW;
    localparam int HALF = (NMAX / 2) * DW;

    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);

    // R2
    out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd0 && in_valid) |=> core_start);

    // R2
    post_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd1 && core_valid) |=> out_valid);

    // R3
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd1 && in_valid) |=> !core_start);

    // R4
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd1 && $past(state) == 2'd1) |-> ($stable(core_inv) && $stable(core_size32)));

    // R11
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !core_size32) |-> (out_vec[VW-1:HALF] == '0));

endmodule

bind wp_adjust_wrap wp_adjust_chk #(.DW(DW), .NMAX(NMAX)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .core_start(core_start),
    .core_valid(core_valid), .core_inv(core_inv), .core_size32(core_size32),
    .out_valid(out_valid), .out_vec(out_vec), .state(state));

// File: tb/tb_wp_adjust_wrap.sv
module tb_wp_adjust_wrap;
    localparam int DW = 16;
    localparam int NMAX = 32;
    localparam int VW = DW * NMAX;
    localparam logic [wp_pkg::TAB_W-1:0] T16 = wp_pkg::band_table(16);
    localparam logic [wp_pkg::TAB_W-1:0] T32 = wp_pkg::band_table(32);
    typedef int vec_t [NMAX];

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_inv = 0, in_size32 = 0;
    logic [1:0] in_kind = 0;
    logic [VW-1:0] in_vec = '0, core_vec_i = '0;
    logic core_valid = 0;
    logic core_start, core_inv, core_size32, out_valid;
    logic [VW-1:0] core_vec_o, out_vec;
    logic z_core_start, z_core_inv, z_core_size32, z_out_valid;
    logic [VW-1:0] z_core_vec_o, z_out_vec;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    wp_adjust_wrap dut (.clk, .rst_n, .in_valid, .in_inv, .in_kind, .in_size32, .in_vec,
        .core_start, .core_inv, .core_size32, .core_vec_o, .core_valid, .core_vec_i,
        .out_valid, .out_vec);

    wp_adjust_wrap #(.C16('0)) dut_z (.clk, .rst_n, .in_valid, .in_inv, .in_kind, .in_size32,
        .in_vec, .core_start(z_core_start), .core_inv(z_core_inv), .core_size32(z_core_size32),
        .core_vec_o(z_core_vec_o), .core_valid, .core_vec_i, .out_valid(z_out_valid),
        .out_vec(z_out_vec));

    // ---------------- reference arithmetic ----------------
    function automatic int wrapw(int x);
        logic [DW-1:0] b;
        b = x[DW-1:0];
        return int'($signed(b));
    endfunction
    function automatic vec_t unpk(logic [VW-1:0] b);
        vec_t v;
        for (int i = 0; i < NMAX; i++) v[i] = int'($signed(b[i*DW +: DW]));
        return v;
    endfunction
    function automatic logic [VW-1:0] pk(vec_t v);
        logic [VW-1:0] b;
        for (int i = 0; i < NMAX; i++) b[i*DW +: DW] = v[i][DW-1:0];
        return b;
    endfunction
    function automatic vec_t vmask(vec_t v, int n);
        vec_t o;
        for (int i = 0; i < NMAX; i++) o[i] = (i < n) ? v[i] : 0;
        return o;
    endfunction
    function automatic vec_t vrev(vec_t v, int n);
        vec_t o;
        for (int i = 0; i < NMAX; i++) o[i] = (i < n) ? v[n-1-i] : 0;
        return o;
    endfunction
    function automatic vec_t vneg(vec_t v);
        vec_t o;
        for (int i = 0; i < NMAX; i++) o[i] = (i % 2 == 1) ? wrapw(-v[i]) : v[i];
        return o;
    endfunction
    function automatic int coef(int n, int r, int t);
        logic [7:0] c;
        if (n == 16) c = T16[(r*5+t)*8 +: 8];
        else         c = T32[(r*5+t)*8 +: 8];
        return int'($signed(c));
    endfunction
    // R10: y[r] = sum_t A[r][t]*x[r+t-2]; transposed form sums over rows
    function automatic vec_t vband(vec_t v, int n, bit tr);
        vec_t o;
        for (int i = 0; i < NMAX; i++) begin
            int s = 0;
            o[i] = 0;
            if (i < n) begin
                for (int t = 0; t < 5; t++) begin
                    int j = tr ? i + 2 - t : i + t - 2;
                    int r = tr ? j : i;
                    if (j >= 0 && j < n) s += coef(n, r, t) * v[j];
                end
                o[i] = wrapw((s + 32) >>> 6);
            end
        end
        return o;
    endfunction
    // behavioural orthonormal DCT-II core stub
    function automatic vec_t vdct(vec_t v, bit inv, int n);
        vec_t o;
        for (int i = 0; i < NMAX; i++) begin
            real acc = 0.0;
            o[i] = 0;
            if (i < n) begin
                for (int m = 0; m < n; m++) begin
                    int k = inv ? m : i;
                    int p = inv ? i : m;
                    real a = $sqrt(((k == 0) ? 1.0 : 2.0) / n);
                    acc += v[m] * a * $cos(3.14159265358979 * (2*p + 1) * k / (2.0 * n));
                end
                o[i] = $rtoi(acc >= 0.0 ? acc + 0.5 : acc - 0.5);
            end
        end
        return o;
    endfunction
    function automatic vec_t exp_pre(int kind, bit inv, int n, vec_t x);
        vec_t m = vmask(x, n);
        int k = (kind == 3) ? 0 : kind;
        if (k == 1) return inv ? vneg(m) : vrev(vband(m, n, 0), n);
        if (k == 2) return inv ? m : vrev(vband(vrev(m, n), n, 0), n);
        return m;
    endfunction
    function automatic vec_t exp_post(int kind, bit inv, int n, vec_t y);
        vec_t m = vmask(y, n);
        int k = (kind == 3) ? 0 : kind;
        if (k == 1) return inv ? vband(vrev(m, n), n, 1) : vneg(m);
        if (k == 2) return inv ? vrev(vband(vrev(m, n), n, 1), n) : m;
        return m;
    endfunction
    function automatic string tag_of(int kind, bit inv, int n, bit post);
        string s;
        case (kind)
            1: s = inv ? (post ? "R7 R10" : "R7") : (post ? "R6" : "R6 R10");
            2: s = inv ? (post ? "R9 R10" : "R9") : (post ? "R8" : "R8 R10");
            3: s = "R12 R5";
            default: s = "R5";
        endcase
        if (n == 16) s = {s, " R11"};
        return s;
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [VW-1:0] act, logic [VW-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, expv);
        end
    endtask

    // ---------------- cycle model ----------------
    int phase = 0, j_kind = 0, j_n = 16;
    bit j_inv = 0, exp_cs = 0, exp_ov = 0, exp_cinv = 0, mon_en = 0;
    logic [VW-1:0] exp_core, exp_out, zexp_core, zexp_out;

    always @(posedge clk) begin
        if (!rst_n) begin
            phase = 0; exp_cs = 0; exp_ov = 0;
        end else begin
            exp_cs = 0; exp_ov = 0;
            case (phase)
                0: if (in_valid) begin
                    phase = 1; exp_cs = 1;
                    j_kind = in_kind; j_inv = in_inv; j_n = in_size32 ? 32 : 16;
                    exp_core = pk(exp_pre(j_kind, j_inv, j_n, unpk(in_vec)));
                    zexp_core = (j_n == 32) ? exp_core : pk(vmask(unpk(in_vec), 16));
                    exp_cinv = (j_kind == 1 || j_kind == 2) ? !j_inv : j_inv;
                end
                1: if (core_valid) begin
                    phase = 2; exp_ov = 1;
                    exp_out = pk(exp_post(j_kind, j_inv, j_n, unpk(core_vec_i)));
                    zexp_out = (j_n == 32) ? exp_out : pk(vmask(unpk(core_vec_i), 16));
                end
                default: phase = 0;
            endcase
        end
    end

    // ---------------- core stub ----------------
    int cnt = 0, jobs = 0;
    vec_t pend;
    always @(negedge clk) begin
        core_valid = 0;
        if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin core_valid = 1; core_vec_i = pk(pend); end
        end
        if (core_start) begin
            pend = vdct(unpk(core_vec_o), core_inv, core_size32 ? 32 : 16);
            cnt = 2 + (jobs % 3);
            jobs++;
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (mon_en) begin
            chk(core_start == exp_cs, "R2 R3", "core_start", VW'(core_start), VW'(exp_cs));
            chk(out_valid == exp_ov, "R2", "out_valid", VW'(out_valid), VW'(exp_ov));
            chk(z_out_valid == exp_ov, "R12", "z out_valid", VW'(z_out_valid), VW'(exp_ov));
            if (exp_cs) begin
                chk(core_vec_o == exp_core, tag_of(j_kind, j_inv, j_n, 0), "core vector", core_vec_o, exp_core);
                chk(core_inv == exp_cinv, "R4", "core_inv", VW'(core_inv), VW'(exp_cinv));
                chk(core_size32 == (j_n == 32), "R2", "core_size32", VW'(core_size32), VW'(j_n == 32));
                chk(z_core_vec_o == zexp_core, "R12", "z core vector", z_core_vec_o, zexp_core);
                if (j_n == 16)
                    chk(z_core_inv == j_inv, "R12", "z core_inv", VW'(z_core_inv), VW'(j_inv));
            end
            if (exp_ov) begin
                chk(out_vec == exp_out, tag_of(j_kind, j_inv, j_n, 1), "out vector", out_vec, exp_out);
                chk(z_out_vec == zexp_out, "R12", "z out vector", z_out_vec, zexp_out);
            end
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [VW-1:0] make(int seed);
        vec_t v;
        for (int i = 0; i < NMAX; i++) v[i] = ((seed * 37 + i * 53 + seed * i * 7) % 401) - 200;
        return pk(v);
    endfunction

    task automatic run_job(int kind, bit inv, bit wide, int seed);
        @(negedge clk);
        in_valid = 1; in_kind = kind[1:0]; in_inv = inv; in_size32 = wide; in_vec = make(seed);
        @(negedge clk);
        in_valid = 0;
        while (phase != 0) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(core_start == 0 && out_valid == 0, "R1", "reset outputs", VW'({core_start, out_valid}), '0);
        @(negedge clk); rst_n = 1; mon_en = 1;
        @(negedge clk);
        // R1
        chk(core_start == 0 && out_valid == 0, "R1", "after reset", VW'({core_start, out_valid}), '0);
        for (int w = 0; w < 2; w++)
            for (int k = 0; k < 4; k++)
                for (int d = 0; d < 2; d++)
                    for (int s = 0; s < 2; s++)
                        run_job(k, d[0], w[0], 1 + s * 11 + k * 3 + w * 5 + d);
        // R3: request held high across busy cycles with changing data and controls
        @(negedge clk);
        in_valid = 1;
        for (int c = 0; c < 25; c++) begin
            in_vec = make(100 + c); in_kind = c[1:0]; in_inv = c[2]; in_size32 = c[3];
            @(negedge clk);
        end
        in_valid = 0;
        while (phase != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule